// File: doc/BRIEF.md
# Drift-Corrected Time-of-Day Counter

This block keeps a free-running time of day as three fields: seconds, whole nanoseconds and a 16-bit fraction of a nanosecond. On every clock cycle it adds a programmed clock period to that time. The period is a fixed-point value with whole and fractional nanoseconds, and the fraction is the true fraction times 65536. A period such as 6.4 ns cannot be held exactly in 16 fractional bits, and the small part that is lost would make the time drift.

To cancel that drift, a second path adds a separate correction value once every N cycles, where N is programmable. For a 6.4 ns clock the fraction is stored as 0x6666 and 0.4/65536 ns is dropped each cycle. Over five cycles the lost amount grows to exactly 2/65536 ns. Adding 0x0002 fractional nanoseconds once every five cycles therefore makes the count exact.

Software programs the period, the correction and the correction interval through a simple write/read register port. The time is presented in parallel on the output pins. When the nanosecond count reaches one second it wraps and the seconds field counts up.

Top module: `tod_drift_clock`

## Requirements
- R1: After reset the time outputs are zero, and all three registers read back as zero.
- R2: The registers sit at byte addresses 0x00 (period), 0x04 (correction) and 0x08 (interval). The period and correction registers hold whole nanoseconds in bits 19:16 and fractional nanoseconds in bits 15:0. The interval register holds a cycle count in bits 15:0. Bits that are not implemented read back as zero.
- R3: On every clock cycle the time advances by the programmed period. A carry out of the 16-bit fraction is added into the nanoseconds in the same cycle.
- R4: With a nonzero interval N, the correction is added on top of the period exactly once every N cycles. The correction lands on the N-th edge after the interval register is written.
- R5: With an interval of zero the correction is never applied, whatever its value.
- R6: Writing the interval register restarts the cycle count. This holds even when the new value equals the old one.
- R7: When the nanoseconds reach NS_PER_SEC or more, NS_PER_SEC is subtracted from them and the seconds go up by one. The nanoseconds output always stays below NS_PER_SEC.
- R8: With period 0x6_6666, correction 0x0_0002 and interval 5, every 5 cycles advance the time by exactly 32 ns, with no fractional residue.
- R9: A write to any other address changes no register and no time value. Such an address reads back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| tod_sec | output | SEC_W (48) | Seconds |
| tod_ns | output | clog2(NS_PER_SEC) (30) | Nanoseconds, always below NS_PER_SEC |
| tod_fns | output | 16 | Fractional nanoseconds (units of 1/65536 ns) |

## Verification
Three things can happen on a single edge: the periodic correction, a carry out of the fraction, and the wrap from nanoseconds into seconds. The bench provokes this with a small NS_PER_SEC override, large period and correction values, and an interval of one. These settings make corrections and wraps coincide often, and constrained-random traffic with interval writes landing on correction cycles adds more cases. The time is modelled as a single count in units of 1/65536 ns and is compared with the outputs after every edge. A second collision is an interval write on the cycle the correction is due. The bench judges it by the exact number of edges until the next correction.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int PNS_W  = 4;
  localparam int FNS_W  = 16;
  localparam int STEP_W = PNS_W + FNS_W;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_CORR   = 8'h04;
  localparam logic [ADDR_W-1:0] ADDR_IVAL   = 8'h08;

  typedef struct packed {
    logic [PNS_W-1:0] ns;
    logic [FNS_W-1:0] fns;
  } tod_step_t;
endpackage

// File: rtl/tod_rst_sync.sv
module tod_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output tod_step_t         period_q,
  output tod_step_t         corr_q,
  output logic [RATE_W-1:0] ival_q,
  output logic              ival_wr
);
  logic      period_we, corr_we;
  tod_step_t period_d, corr_d;
  logic [RATE_W-1:0] ival_d;
  logic unused_wdata_bits;

  assign unused_wdata_bits = ^wdata[DATA_W-1:STEP_W];

  // next-state
  always_comb begin
    period_we = wr_en && (addr == ADDR_PERIOD);
    corr_we   = wr_en && (addr == ADDR_CORR);
    ival_wr   = wr_en && (addr == ADDR_IVAL);
    period_d  = period_we ? tod_step_t'(wdata[STEP_W-1:0]) : period_q;
    corr_d    = corr_we   ? tod_step_t'(wdata[STEP_W-1:0]) : corr_q;
    ival_d    = ival_wr   ? wdata[RATE_W-1:0]             : ival_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      corr_q   <= '0;
      ival_q   <= '0;
    end else begin
      period_q <= period_d;
      corr_q   <= corr_d;
      ival_q   <= ival_d;
    end
  end

  // readback
  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_PERIOD: rdata = DATA_W'(period_q);
      ADDR_CORR:   rdata = DATA_W'(corr_q);
      ADDR_IVAL:   rdata = DATA_W'(ival_q);
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/tod_rate_counter.sv
module tod_rate_counter #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] ival,
  input  logic              restart,
  output logic              corr_due,
  output logic [RATE_W-1:0] cnt_q
);
  logic [RATE_W-1:0] cnt_d;
  logic              active;

  always_comb begin
    active   = (ival != '0);
    corr_due = active && (cnt_q == ival - 1'b1);
    if (restart || !active || corr_due) cnt_d = '0;
    else                                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tod_accum.sv
module tod_accum
  import tod_pkg::*;
#(
  parameter int NS_PER_SEC = 1_000_000_000,
  parameter int SEC_W      = 48,
  parameter int NS_W       = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tod_step_t        period,
  input  tod_step_t        corr,
  input  logic             corr_due,
  output logic [SEC_W-1:0] sec_q,
  output logic [NS_W-1:0]  ns_q,
  output logic [FNS_W-1:0] fns_q,
  output logic             sec_wrap
);
  localparam logic [NS_W:0] NS_LIM = (NS_W+1)'(NS_PER_SEC);

  logic [PNS_W:0]   add_ns;
  logic [FNS_W:0]   add_fns;
  logic [FNS_W+1:0] fns_sum;
  logic [1:0]       fns_carry;
  logic [NS_W:0]    ns_sum;
  logic [SEC_W-1:0] sec_d;
  logic [NS_W-1:0]  ns_d;
  logic [FNS_W-1:0] fns_d;

  always_comb begin
    add_ns    = {1'b0, period.ns}  + (corr_due ? {1'b0, corr.ns}  : '0);
    add_fns   = {1'b0, period.fns} + (corr_due ? {1'b0, corr.fns} : '0);
    fns_sum   = {2'b00, fns_q} + {1'b0, add_fns};
    fns_carry = fns_sum[FNS_W+1:FNS_W];
    ns_sum    = {1'b0, ns_q} + (NS_W+1)'(add_ns) + (NS_W+1)'(fns_carry);
    sec_wrap  = (ns_sum >= NS_LIM);
    fns_d     = fns_sum[FNS_W-1:0];
    ns_d      = sec_wrap ? NS_W'(ns_sum - NS_LIM) : ns_sum[NS_W-1:0];
    sec_d     = sec_q + SEC_W'(sec_wrap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      ns_q  <= '0;
      fns_q <= '0;
    end else begin
      sec_q <= sec_d;
      ns_q  <= ns_d;
      fns_q <= fns_d;
    end
  end
endmodule

// File: rtl/tod_drift_clock.sv
module tod_drift_clock
  import tod_pkg::*;
#(
  parameter  int NS_PER_SEC = 1_000_000_000,
  parameter  int SEC_W      = 48,
  parameter  int RATE_W     = 16,
  localparam int NS_W       = $clog2(NS_PER_SEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [SEC_W-1:0]  tod_sec,
  output logic [NS_W-1:0]   tod_ns,
  output logic [FNS_W-1:0]  tod_fns
);
  logic              rst_n_sync;
  tod_step_t         period_q, corr_q;
  logic [RATE_W-1:0] ival_q, rate_cnt;
  logic              ival_wr, corr_due, sec_wrap;

  tod_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  tod_regs #(.RATE_W(RATE_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .period_q (period_q),
    .corr_q   (corr_q),
    .ival_q   (ival_q),
    .ival_wr  (ival_wr)
  );

  tod_rate_counter #(.RATE_W(RATE_W)) u_rate (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .ival     (ival_q),
    .restart  (ival_wr),
    .corr_due (corr_due),
    .cnt_q    (rate_cnt)
  );

  tod_accum #(.NS_PER_SEC(NS_PER_SEC), .SEC_W(SEC_W), .NS_W(NS_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .period   (period_q),
    .corr     (corr_q),
    .corr_due (corr_due),
    .sec_q    (tod_sec),
    .ns_q     (tod_ns),
    .fns_q    (tod_fns),
    .sec_wrap (sec_wrap)
  );
endmodule

// File: rtl/tod_drift_chk.sv
module tod_drift_chk #(
  parameter int NS_PER_SEC = 1_000_000_000,
  parameter int SEC_W      = 48,
  parameter int RATE_W     = 16,
  parameter int NS_W       = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              corr_due,
  input logic              ival_wr,
  input logic [RATE_W-1:0] ival,
  input logic [RATE_W-1:0] cnt,
  input logic [SEC_W-1:0]  sec,
  input logic [NS_W-1:0]   ns
);
  assert_ns_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ns < NS_W'(NS_PER_SEC));

  assert_sec_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec != $past(sec)) |-> (sec == $past(sec) + SEC_W'(1)));

  assert_time_forward_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(sec) |-> (ns >= $past(ns)));

  assert_no_corr_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ival == '0) |-> !corr_due);

  assert_corr_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_due && !ival_wr && (ival > RATE_W'(1))) |=> !corr_due);

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ival_wr |=> (cnt == '0));
endmodule

bind tod_drift_clock tod_drift_chk #(
  .NS_PER_SEC (NS_PER_SEC),
  .SEC_W      (SEC_W),
  .RATE_W     (RATE_W),
  .NS_W       (NS_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .corr_due (corr_due),
  .ival_wr  (ival_wr),
  .ival     (ival_q),
  .cnt      (rate_cnt),
  .sec      (tod_sec),
  .ns       (tod_ns)
);

// File: tb/tb_tod_drift_clock.sv
module tb_tod_drift_clock;
  localparam int NSPS   = 1000;
  localparam int SEC_W  = 48;
  localparam int RATE_W = 16;
  localparam int NS_W   = $clog2(NSPS);
  localparam logic [95:0] SECU = 96'(NSPS) * 96'd65536;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [7:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [SEC_W-1:0]  tod_sec;
  logic [NS_W-1:0]   tod_ns;
  logic [15:0]       tod_fns;

  int checks = 0;
  int errors = 0;
  bit run_chk = 1'b0;
  bit finished = 1'b0;

  // bench-side model of the programmed state and of the time in 1/65536 ns
  logic [19:0] m_per, m_corr;
  logic [15:0] m_ival, m_cnt;
  logic [95:0] m_total;
  string       m_tag = "R1";

  always #10 clk = ~clk;

  tod_drift_clock #(.NS_PER_SEC(NSPS), .SEC_W(SEC_W), .RATE_W(RATE_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tod_sec(tod_sec), .tod_ns(tod_ns), .tod_fns(tod_fns)
  );

  function automatic logic [95:0] units(logic [19:0] s);
    return 96'(s[19:16]) * 96'd65536 + 96'(s[15:0]);
  endfunction

  function automatic logic [95:0] dut_units();
    return (96'(tod_sec) * 96'(NSPS) + 96'(tod_ns)) * 96'd65536 + 96'(tod_fns);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_per = '0; m_corr = '0; m_ival = '0; m_cnt = '0; m_total = '0; m_tag = "R1";
    end else begin
      logic due;
      logic [95:0] old_sec;
      due     = (m_ival != 16'd0) && (m_cnt == m_ival - 16'd1);
      old_sec = m_total / SECU;
      m_total = m_total + units(m_per) + (due ? units(m_corr) : 96'd0);
      if (m_total / SECU != old_sec) m_tag = "R7";
      else if (due)                  m_tag = "R4";
      else                           m_tag = "R3";
      m_cnt = (due || m_ival == 16'd0) ? 16'd0 : m_cnt + 16'd1;
      if (wr_en) begin
        case (addr)
          8'h00: m_per  = wdata[19:0];
          8'h04: m_corr = wdata[19:0];
          8'h08: begin m_ival = wdata[15:0]; m_cnt = 16'd0; end
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run_chk && !finished) check(m_tag, dut_units(), m_total);
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    addr = a;
    #1;
    check(req, 96'(rdata), 96'(exp));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [95:0] t0;
    logic [SEC_W-1:0] s0;
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1'b1;
    idle(4);
    run_chk = 1'b1;

    // R1: reset state
    check("R1", dut_units(), 96'd0);
    rd(8'h00, 32'h0, "R1");
    rd(8'h04, 32'h0, "R1");
    rd(8'h08, 32'h0, "R1");

    // R2: layout and unimplemented bits
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, 32'h000F_FFFF, "R2");
    wr(8'h04, 32'h1234_5678); rd(8'h04, 32'h0004_5678, "R2");
    wr(8'h08, 32'hABCD_1234); rd(8'h08, 32'h0000_1234, "R2");

    // R9: unmapped address
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0, "R9");
    rd(8'h08, 32'h0000_1234, "R9");
    rd(8'h00, 32'h000F_FFFF, "R9");

    // R8: 6.4 ns period with correction every 5 cycles
    wr(8'h04, 32'h0000_0002);
    wr(8'h00, 32'h0006_6666);
    wr(8'h08, 32'h0000_0005);
    t0 = dut_units();
    for (int k = 1; k <= 20; k++) begin
      idle(5);
      check("R8", dut_units() - t0, 96'(k) * 96'd32 * 96'd65536);
    end

    // R4: correction lands on the N-th edge after the interval write
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0001_0000);
    wr(8'h08, 32'h4);
    t0 = dut_units();
    idle(3); check("R4", dut_units() - t0, 96'd0);
    idle(1); check("R4", dut_units() - t0, 96'd65536);

    // R6: rewriting the same interval restarts the count
    idle(2);
    wr(8'h08, 32'h4);
    t0 = dut_units();
    idle(3); check("R6", dut_units() - t0, 96'd0);
    idle(1); check("R6", dut_units() - t0, 96'd65536);

    // R5: interval zero never applies the correction
    wr(8'h08, 32'h0);
    wr(8'h04, 32'h0005_1234);
    wr(8'h00, 32'h0003_8000);
    t0 = dut_units();
    idle(20);
    check("R5", dut_units() - t0, 96'd20 * units(20'h3_8000));

    // R7: rollover into seconds
    wr(8'h00, 32'h000F_0000);
    t0 = dut_units();
    s0 = tod_sec;
    idle(200);
    check("R7", 96'(tod_sec - s0), 96'd3);
    check("R7", dut_units() - t0, 96'd3000 * 96'd65536);

    // R4 with R7: correction every cycle, maximal values
    wr(8'h00, 32'h000F_FFFF);
    wr(8'h04, 32'h000F_FFFF);
    wr(8'h08, 32'h1);
    t0 = dut_units();
    idle(100);
    check("R4", dut_units() - t0, 96'd100 * (units(20'hF_FFFF) * 96'd2));

    // constrained random traffic, judged by the per-cycle model check
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel == 0)      wr(8'h00, $urandom);
      else if (sel == 1) wr(8'h04, $urandom);
      else if (sel == 2) wr(8'h08, {$urandom, 16'h0} | 32'($urandom_range(0, 6)));
      else if (sel == 3) wr(8'($urandom), $urandom);
      else               idle(1);
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule